// File: doc/BRIEF.md
# Knockout Tournament Concentrator

This block sits in front of one output port of a packet switch. Every slot it sees N input lanes, each with a valid flag, a destination address and a data word. Packets whose address is not this port's number are dropped at the lane filters. The remaining packets then contend in a cascade of R tournament sections built from 2x2 contention elements. A section passes its single winner to its own output lane and hands all of its losers to the next section. Section k therefore delivers the k-th surviving packet.

In every element the upper (lower-numbered) input wins. The ranking is therefore fixed: output lane k carries the k-th matching packet in ascending input-lane order. Each section registers its result. Delay registers hold back the early sections so that all R output lanes of one slot appear together. A per-slot count reports how many matching packets lost in every section and were discarded. A new slot can enter on every clock cycle.

Top module: `knockout_conc`

## Requirements
- R1: While reset is held, and in the cycle after it, every out_valid bit is 0 and lost_cnt is 0.
- R2: An input lane takes part only when its in_valid is 1 and its in_addr equals the parameter THIS_PORT. Any other lane never appears on an output and never counts as lost.
- R3: Output lane k (k = 0 is the first section) carries the data of the (k+1)-th matching input lane, counted in ascending lane index.
- R4: With M matching packets and M < N_OUT, out_valid bits 0..M-1 are 1 and the higher bits are 0. The set of valid output lanes is always contiguous from lane 0.
- R5: lost_cnt equals M - N_OUT when M > N_OUT and 0 otherwise. It is nonzero only when every output lane is valid.
- R6: All outputs of a slot appear exactly N_OUT clock cycles after the edge that samples the inputs, all in the same cycle.
- R7: Slots presented on consecutive cycles are handled independently, one slot per cycle, without stalls.
- R8: A slot with no matching packet gives all out_valid bits 0 and lost_cnt 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | N_IN | Packet present on each input lane |
| in_addr | input | N_IN x ADDR_W | Destination port of each input lane |
| in_data | input | N_IN x LANE_DW | Payload of each input lane |
| out_valid | output | N_OUT | Section winner present on each output lane |
| out_data | output | N_OUT x LANE_DW | Payload of each section winner |
| lost_cnt | output | CNT_W | Matching packets discarded in this slot |

## Verification
Delivery of winners and discarding of losers happen in the same slot once more than N_OUT packets match. Slots with five and eight matching lanes create this overlap. They are judged by checking that lanes 0..3 hold the lowest-indexed matches while lost_cnt holds the excess. Slots with exactly N_OUT matches mark the point where loss begins. Other slots mix valid non-matching lanes below the matches, which checks that filtering and ranking together neither skip a winner nor count the filtered lanes as lost.

// File: rtl/kc_pkg.sv
package kc_pkg;
  parameter int LANE_DW = 8;

  typedef struct packed {
    logic               valid;
    logic [LANE_DW-1:0] data;
  } lane_t;
endpackage

// File: rtl/kc_element.sv
// 2x2 contention element: the upper input wins whenever it is active.
module kc_element
  import kc_pkg::*;
(
  input  lane_t upper,
  input  lane_t lower,
  output lane_t win,
  output lane_t lose
);
  always_comb begin
    if (upper.valid) begin
      win  = upper;
      lose = lower;
    end else begin
      win  = lower;
      lose = '0;
    end
  end
endmodule

// File: rtl/kc_section.sv
// One tournament section: LANES-1 elements in a chain, registered outputs.
module kc_section
  import kc_pkg::*;
#(
  parameter int N     = 8,
  parameter int LANES = 8
)(
  input  logic  clk,
  input  logic  rst,
  input  lane_t in_l   [LANES],
  output lane_t win_q,
  output lane_t lose_q [N]
);
  lane_t carry  [LANES];
  lane_t lose_c [N];

  assign carry[0] = in_l[0];

  generate
    for (genvar j = 0; j < LANES - 1; j++) begin : g_elem
      kc_element u_elem (
        .upper (carry[j]),
        .lower (in_l[j+1]),
        .win   (carry[j+1]),
        .lose  (lose_c[j])
      );
    end
    for (genvar j = (LANES > 0 ? LANES - 1 : 0); j < N; j++) begin : g_tail
      assign lose_c[j] = '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q <= '0;
      for (int i = 0; i < N; i++) lose_q[i] <= '0;
    end else begin
      win_q  <= carry[LANES-1];
      lose_q <= lose_c;
    end
  end
endmodule

// File: rtl/kc_delay.sv
// Alignment delay line for an early section winner.
module kc_delay
  import kc_pkg::*;
#(
  parameter int DEPTH = 1
)(
  input  logic  clk,
  input  logic  rst,
  input  lane_t d,
  output lane_t q
);
  lane_t sr [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) sr[i] <= '0;
    end else begin
      sr[0] <= d;
      for (int i = 1; i < DEPTH; i++) sr[i] <= sr[i-1];
    end
  end

  assign q = sr[DEPTH-1];
endmodule

// File: rtl/knockout_conc.sv
module knockout_conc
  import kc_pkg::*;
#(
  parameter int N_IN      = 8,
  parameter int N_OUT     = 4,
  parameter int ADDR_W    = 3,
  parameter int THIS_PORT = 5,
  parameter int CNT_W     = $clog2(N_IN + 1)
)(
  input  logic                              clk,
  input  logic                              rst,
  input  logic [N_IN-1:0]                   in_valid,
  input  logic [N_IN-1:0][ADDR_W-1:0]       in_addr,
  input  logic [N_IN-1:0][LANE_DW-1:0]      in_data,
  output logic [N_OUT-1:0]                  out_valid,
  output logic [N_OUT-1:0][LANE_DW-1:0]     out_data,
  output logic [CNT_W-1:0]                  lost_cnt
);
  localparam logic [ADDR_W-1:0] PORT_SEL = THIS_PORT[ADDR_W-1:0];

  // stg[k] holds the lanes entering section k; stg[N_OUT] holds final losers
  lane_t stg   [N_OUT+1][N_IN];
  lane_t win_w [N_OUT];
  lane_t win_d [N_OUT];

  generate
    for (genvar i = 0; i < N_IN; i++) begin : g_filter
      assign stg[0][i] = {in_valid[i] && (in_addr[i] == PORT_SEL), in_data[i]};
    end

    for (genvar k = 0; k < N_OUT; k++) begin : g_sec
      kc_section #(.N(N_IN), .LANES(N_IN - k)) u_sec (
        .clk    (clk),
        .rst    (rst),
        .in_l   (stg[k][0:N_IN-k-1]),
        .win_q  (win_w[k]),
        .lose_q (stg[k+1])
      );
      if (k == N_OUT - 1) begin : g_last
        assign win_d[k] = win_w[k];
      end else begin : g_align
        kc_delay #(.DEPTH(N_OUT - 1 - k)) u_dly (
          .clk (clk),
          .rst (rst),
          .d   (win_w[k]),
          .q   (win_d[k])
        );
      end
      assign out_valid[k] = win_d[k].valid;
      assign out_data[k]  = win_d[k].data;
    end
  endgenerate

  always_comb begin
    lost_cnt = '0;
    for (int i = 0; i < N_IN; i++)
      lost_cnt = lost_cnt + CNT_W'(stg[N_OUT][i].valid);
  end
endmodule

// File: rtl/knockout_conc_chk.sv
module knockout_conc_chk #(
  parameter int N_IN      = 8,
  parameter int N_OUT     = 4,
  parameter int ADDR_W    = 3,
  parameter int THIS_PORT = 5,
  parameter int CNT_W     = 4
)(
  input logic                        clk,
  input logic                        rst,
  input logic [N_IN-1:0]             in_valid,
  input logic [N_IN-1:0][ADDR_W-1:0] in_addr,
  input logic [N_OUT-1:0]            out_valid,
  input logic [CNT_W-1:0]            lost_cnt
);
  logic [CNT_W-1:0] hits;
  logic [CNT_W-1:0] hit_pipe [N_OUT];
  logic [N_OUT-1:0] ov_inc;
  logic             rst_q;

  always_comb begin
    hits = '0;
    for (int i = 0; i < N_IN; i++)
      if (in_valid[i] && in_addr[i] == THIS_PORT[ADDR_W-1:0]) hits = hits + 1'b1;
  end

  assign ov_inc = out_valid + N_OUT'(1);

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_OUT; i++) hit_pipe[i] <= '0;
    end else begin
      hit_pipe[0] <= hits;
      for (int i = 1; i < N_OUT; i++) hit_pipe[i] <= hit_pipe[i-1];
    end
  end

  always @(posedge clk) begin
    if (rst_q === 1'b1)
      AST_RESET_IDLE: assert (out_valid == '0 && lost_cnt == '0); // R1
    rst_q <= rst;
  end

  AST_CONTIGUOUS: assert property (@(posedge clk) disable iff (rst)
    (ov_inc & out_valid) == '0); // R4

  AST_LOSS_ONLY_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
    (lost_cnt != '0) |-> (&out_valid)); // R5

  AST_CONSERVE: assert property (@(posedge clk) disable iff (rst)
    ($countones(out_valid) + int'(lost_cnt)) == int'(hit_pipe[N_OUT-1])); // R6
endmodule

bind knockout_conc knockout_conc_chk #(
  .N_IN(N_IN), .N_OUT(N_OUT), .ADDR_W(ADDR_W), .THIS_PORT(THIS_PORT), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_addr(in_addr),
  .out_valid(out_valid), .lost_cnt(lost_cnt)
);

// File: tb/knockout_conc_test.sv
module knockout_conc_test;
  import kc_pkg::*;

  localparam int N_IN      = 8;
  localparam int N_OUT     = 4;
  localparam int ADDR_W    = 3;
  localparam int THIS_PORT = 5;
  localparam int CNT_W     = $clog2(N_IN + 1);

  logic                         clk = 1'b0;
  logic                         rst = 1'b1;
  logic [N_IN-1:0]              in_valid = '0;
  logic [N_IN-1:0][ADDR_W-1:0]  in_addr  = '0;
  logic [N_IN-1:0][LANE_DW-1:0] in_data  = '0;
  logic [N_OUT-1:0]             out_valid;
  logic [N_OUT-1:0][LANE_DW-1:0] out_data;
  logic [CNT_W-1:0]             lost_cnt;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    logic [N_OUT-1:0]              v;
    logic [N_OUT-1:0][LANE_DW-1:0] d;
    int                            lost;
    int                            due;
    string                         tag;
  } exp_t;
  exp_t sbq[$];

  knockout_conc #(.N_IN(N_IN), .N_OUT(N_OUT), .ADDR_W(ADDR_W), .THIS_PORT(THIS_PORT)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_addr(in_addr), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data), .lost_cnt(lost_cnt)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Driver: apply one slot (v = present lanes, m = lanes addressed to this port),
  // compute the expected ranking and push it; due N_OUT edges later (R6).
  task automatic slot(input logic [N_IN-1:0] v, input logic [N_IN-1:0] m,
                      input int sn, input string tag);
    exp_t e;
    int k;
    @(negedge clk);
    e.v = '0; e.d = '0; e.lost = 0; e.tag = tag; k = 0;
    for (int i = 0; i < N_IN; i++) begin
      in_valid[i] = v[i];
      in_addr[i]  = m[i] ? ADDR_W'(THIS_PORT) : ADDR_W'(THIS_PORT + 1 + i % 2);
      in_data[i]  = LANE_DW'((sn << 4) | i);
      if (v[i] && m[i]) begin
        if (k < N_OUT) begin
          e.v[k] = 1'b1;
          e.d[k] = in_data[i];
        end else begin
          e.lost++;
        end
        k++;
      end
    end
    e.due = cyc + N_OUT;
    sbq.push_back(e);
  endtask

  // Monitor: compare against the scoreboard away from the active edge.
  always @(negedge clk) begin
    if (!rst && sbq.size() > 0 && sbq[0].due == cyc) begin
      exp_t e;
      e = sbq.pop_front();
      for (int k = 0; k < N_OUT; k++) begin
        check(out_valid[k] == e.v[k], e.tag, $sformatf("lane%0d valid", k), out_valid[k], e.v[k]);
        if (e.v[k])
          check(out_data[k] == e.d[k], e.tag, $sformatf("lane%0d data", k), out_data[k], e.d[k]);
      end
      check(int'(lost_cnt) == e.lost, e.tag, "lost_cnt", lost_cnt, e.lost);
    end
  end

  initial begin
    repeat (10000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs idle during reset
    check(out_valid == '0, "R1", "out_valid in reset", out_valid, 0);
    check(lost_cnt == '0, "R1", "lost_cnt in reset", lost_cnt, 0);
    rst = 1'b0;
    // Back-to-back slots, one per cycle (R7); alignment via due cycle (R6)
    slot(8'b0010_0000, 8'hFF, 1, "R3_single");
    slot(8'hFF,        8'hFF, 2, "R5_all_match");
    slot(8'b0100_1111, 8'b0100_1010, 3, "R2_R4_mixed");
    slot(8'h00,        8'hFF, 4, "R8_empty");
    slot(8'hFF,        8'h00, 5, "R2_R8_foreign");
    slot(8'hF0,        8'hF0, 6, "R5_exact_fit");
    slot(8'hF8,        8'hFF, 7, "R5_one_lost");
    slot(8'b1000_0001, 8'hFF, 8, "R4_ends");
    slot(8'b1010_1010, 8'b1111_0000, 9, "R3_R4_filter_low");
    slot(8'hFF,        8'b0111_1110, 10, "R3_R5_R6_interior");
    for (int i = 0; i < N_OUT + 2; i++) slot(8'h00, 8'h00, 11, "R6_R7_drain");
    repeat (N_OUT + 2) @(negedge clk);
    check(sbq.size() == 0, "R6", "scoreboard left", sbq.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule